// File: doc/BRIEF.md
# Destination Address Filter

This block decides whether a received frame is kept, based only on its 48-bit destination address. A one-cycle start pulse presents the address and three receive-mode bits. Two clock edges later the block returns a verdict: accept or reject, plus a flag that says whether the frame was taken as multicast or as broadcast. The rules are tried in a fixed order. The promiscuous rule comes first, then all-multicast, then broadcast, and last a lookup in a 16-entry table of station addresses. A 16-bit enable mask selects which table entries take part in the lookup.

The table is filled by a built-in loader that walks a list of four-word descriptors in memory. It uses a simple word-read port: one request at a time, and a valid strobe that returns the data. The caller gives a base word address and a descriptor count. The loader writes each addressed entry, then reads one more word and uses it as the new enable mask. A one-cycle done pulse marks the end of the load.

Top module: `dest_addr_filter`

## Requirements
- R1: After a synchronous reset, match_valid, load_busy, load_done and rd_req are low. Every table entry and the whole enable mask are cleared, so with all modes off even the all-zero address is rejected.
- R2: Each start pulse gives a single-cycle match_valid exactly two clock edges after the edge that samples it, whatever the mode. The address and mode are captured with the start, and starts on consecutive cycles give results on consecutive cycles.
- R3: With rx_mode bit 0 (promiscuous) set, an address whose bit 0 is clear is accepted with both flags low, whether or not it is in the table.
- R4: With rx_mode bit 1 (all-multicast) set, an address whose bit 0 is set is accepted with the multicast flag. This rule ranks above broadcast, so the all-ones address then carries the multicast flag and not the broadcast flag.
- R5: With rx_mode bit 2 (broadcast) set, the all-ones address is accepted with the broadcast flag, provided neither earlier rule applied.
- R6: When no mode rule applies, the address is accepted with both flags low if and only if it exactly equals an entry whose enable-mask bit is set. Entries that are not enabled never match.
- R7: An address that meets no rule is rejected: match_accept, match_bcast and match_mcast are all low in the valid cycle.
- R8: A descriptor is four words at pointer+0 to pointer+3. In word 0, only bits 3:0 are used, as the entry index. Words 1, 2 and 3 hold the address bytes, low byte first: word 1 holds bytes 0 and 1, word 2 holds bytes 2 and 3, word 3 holds bytes 4 and 5. On dst_addr, byte k sits at bits 8k+7:8k, and bit 0 is the group bit. A later descriptor with the same index overwrites the earlier one.
- R9: A load with count c (5 bits) reads descriptor words at base to base+4c-1, then reads the mask word at base+4c, for 4c+1 requests in total. A count of zero reads only the mask, at base. Mask bit i enables entry i.
- R10: load_busy rises on the edge that samples load_start and falls when the mask word arrives. load_done is a single-cycle pulse in the first cycle that busy is low. A load_start while busy is ignored.
- R11: rd_req is a single-cycle pulse with at most one request outstanding. The next request is issued only after rd_valid has returned the data for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_start | input | 1 | Start a classification of dst_addr |
| rx_mode | input | 3 | Bit 0 promiscuous, bit 1 all-multicast, bit 2 broadcast accept |
| dst_addr | input | 48 | Destination address, byte k at bits 8k+7:8k |
| match_valid | output | 1 | Verdict valid for one cycle |
| match_accept | output | 1 | Frame accepted |
| match_bcast | output | 1 | Accepted as broadcast |
| match_mcast | output | 1 | Accepted as multicast |
| load_start | input | 1 | Begin a table load |
| load_base | input | 16 | Word address of the first descriptor |
| load_count | input | 5 | Number of descriptors |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | Load finished, one-cycle pulse |
| rd_req | output | 1 | Word read request |
| rd_addr | output | 16 | Word address of the read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Read data |

## Verification
The hardest case to reach is a table whose contents depend on the order of the walk. To get there, the stimulus loads descriptors in reverse index order, puts junk in the unused upper bits of word 0, and loads the same index twice so that only the second address may survive. It also gives a zero-count load that must replace only the mask. A second load_start is issued in the middle of a long walk, and the request count together with the later lookups shows that it was ignored. The memory model returns each read after a latency that varies, which exercises the one-outstanding-request rule. The mode priority is then swept over all eight mode settings against unicast-hit, unicast-miss, multicast and broadcast addresses.

// File: rtl/daf_pkg.sv
package daf_pkg;

    localparam int WORD_W     = 16;
    localparam int MAC_W      = 48;
    localparam int CNT_W      = 5;
    localparam int DESC_WORDS = 4;
    localparam int MODE_W     = 3;

    // Receive mode, bit 0 promiscuous, bit 1 all-multicast, bit 2 broadcast
    typedef struct packed {
        logic bcast;
        logic allmc;
        logic promisc;
    } mode_t;

    typedef struct packed {
        logic accept;
        logic bcast;
        logic mcast;
    } verdict_t;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_NEXT,
        LD_DREQ,
        LD_DWAIT,
        LD_MREQ,
        LD_MWAIT
    } ld_state_t;

    function automatic logic is_group(input logic [MAC_W-1:0] a);
        return a[0];
    endfunction

    function automatic logic is_broadcast(input logic [MAC_W-1:0] a);
        return &a;
    endfunction

    // Fixed-priority verdict: promiscuous, all-multicast, broadcast, table
    function automatic verdict_t decide(input mode_t m,
                                        input logic [MAC_W-1:0] a,
                                        input logic table_hit);
        verdict_t v;
        v = '0;
        if (m.promisc && !is_group(a)) begin
            v.accept = 1'b1;
        end else if (m.allmc && is_group(a)) begin
            v.accept = 1'b1;
            v.mcast  = 1'b1;
        end else if (m.bcast && is_broadcast(a)) begin
            v.accept = 1'b1;
            v.bcast  = 1'b1;
        end else if (table_hit) begin
            v.accept = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/daf_cam_store.sv
module daf_cam_store
    import daf_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ent_we,
    input  logic [$clog2(N_ENTRIES)-1:0] ent_idx,
    input  logic [MAC_W-1:0]            ent_data,
    input  logic                        mask_we,
    input  logic [N_ENTRIES-1:0]        mask_data,
    input  logic [MAC_W-1:0]            lookup_addr,
    output logic                        table_hit
);

    localparam int IDX_W = $clog2(N_ENTRIES);

    logic [N_ENTRIES-1:0] mask_q;
    logic [N_ENTRIES-1:0] hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_data;
        end
    end

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        logic [MAC_W-1:0] val_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (ent_we && (ent_idx == IDX_W'(g))) begin
                val_q <= ent_data;
            end
        end

        assign hit_vec[g] = mask_q[g] && (val_q == lookup_addr);
    end

    assign table_hit = |hit_vec;

endmodule

// File: rtl/daf_cam_loader.sv
module daf_cam_loader
    import daf_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int ADDR_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_start,
    input  logic [ADDR_W-1:0]            load_base,
    input  logic [CNT_W-1:0]             load_count,
    output logic                         load_busy,
    output logic                         load_done,
    output logic                         rd_req,
    output logic [ADDR_W-1:0]            rd_addr,
    input  logic                         rd_valid,
    input  logic [WORD_W-1:0]            rd_data,
    output logic                         ent_we,
    output logic [$clog2(N_ENTRIES)-1:0] ent_idx,
    output logic [MAC_W-1:0]             ent_data,
    output logic                         mask_we,
    output logic [N_ENTRIES-1:0]         mask_data
);

    localparam int IDX_W  = $clog2(N_ENTRIES);
    localparam int WSEL_W = $clog2(DESC_WORDS);
    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(DESC_WORDS - 1);

    ld_state_t           state_q;
    logic [ADDR_W-1:0]   ptr_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [WSEL_W-1:0]   wsel_q;
    logic [IDX_W-1:0]    idx_q;
    logic [WORD_W-1:0]   lo_q;
    logic [WORD_W-1:0]   mid_q;
    logic                done_q;

    always_comb begin
        rd_req    = (state_q == LD_DREQ) || (state_q == LD_MREQ);
        rd_addr   = (state_q == LD_DREQ) ? (ptr_q + ADDR_W'(wsel_q)) : ptr_q;
        ent_we    = (state_q == LD_DWAIT) && rd_valid && (wsel_q == LAST_WORD);
        ent_idx   = idx_q;
        ent_data  = {rd_data, mid_q, lo_q};
        mask_we   = (state_q == LD_MWAIT) && rd_valid;
        mask_data = rd_data[N_ENTRIES-1:0];
        load_busy = (state_q != LD_IDLE);
        load_done = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LD_IDLE;
            ptr_q   <= '0;
            cnt_q   <= '0;
            wsel_q  <= '0;
            idx_q   <= '0;
            lo_q    <= '0;
            mid_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                LD_IDLE: begin
                    if (load_start) begin
                        ptr_q   <= load_base;
                        cnt_q   <= load_count;
                        state_q <= LD_NEXT;
                    end
                end
                LD_NEXT: begin
                    if (cnt_q == '0) begin
                        state_q <= LD_MREQ;
                    end else begin
                        wsel_q  <= '0;
                        state_q <= LD_DREQ;
                    end
                end
                LD_DREQ: begin
                    state_q <= LD_DWAIT;
                end
                LD_DWAIT: begin
                    if (rd_valid) begin
                        unique case (wsel_q)
                            WSEL_W'(0): idx_q <= rd_data[IDX_W-1:0];
                            WSEL_W'(1): lo_q  <= rd_data;
                            WSEL_W'(2): mid_q <= rd_data;
                            default: ;
                        endcase
                        if (wsel_q == LAST_WORD) begin
                            cnt_q   <= cnt_q - 1'b1;
                            ptr_q   <= ptr_q + ADDR_W'(DESC_WORDS);
                            state_q <= LD_NEXT;
                        end else begin
                            wsel_q  <= wsel_q + 1'b1;
                            state_q <= LD_DREQ;
                        end
                    end
                end
                LD_MREQ: begin
                    state_q <= LD_MWAIT;
                end
                LD_MWAIT: begin
                    if (rd_valid) begin
                        done_q  <= 1'b1;
                        state_q <= LD_IDLE;
                    end
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/daf_classifier.sv
module daf_classifier
    import daf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              match_start,
    input  logic [MODE_W-1:0] rx_mode,
    input  logic [MAC_W-1:0]  dst_addr,
    input  logic              table_hit,
    output logic              match_valid,
    output logic              match_accept,
    output logic              match_bcast,
    output logic              match_mcast
);

    // Stage 1: capture request and table lookup result
    logic             v1_q;
    mode_t            m1_q;
    logic [MAC_W-1:0] a1_q;
    logic             h1_q;

    // Stage 2: registered verdict
    logic             vld_q;
    verdict_t         vrd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q  <= 1'b0;
            m1_q  <= '0;
            a1_q  <= '0;
            h1_q  <= 1'b0;
            vld_q <= 1'b0;
            vrd_q <= '0;
        end else begin
            v1_q <= match_start;
            if (match_start) begin
                m1_q <= mode_t'(rx_mode);
                a1_q <= dst_addr;
                h1_q <= table_hit;
            end
            vld_q <= v1_q;
            vrd_q <= v1_q ? decide(m1_q, a1_q, h1_q) : verdict_t'('0);
        end
    end

    assign match_valid  = vld_q;
    assign match_accept = vrd_q.accept;
    assign match_bcast  = vrd_q.bcast;
    assign match_mcast  = vrd_q.mcast;

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import daf_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int ADDR_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              match_start,
    input  logic [2:0]        rx_mode,
    input  logic [47:0]       dst_addr,
    output logic              match_valid,
    output logic              match_accept,
    output logic              match_bcast,
    output logic              match_mcast,
    input  logic              load_start,
    input  logic [ADDR_W-1:0] load_base,
    input  logic [4:0]        load_count,
    output logic              load_busy,
    output logic              load_done,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [15:0]       rd_data
);

    localparam int IDX_W = $clog2(N_ENTRIES);

    logic                 ent_we;
    logic [IDX_W-1:0]     ent_idx;
    logic [MAC_W-1:0]     ent_data;
    logic                 mask_we;
    logic [N_ENTRIES-1:0] mask_data;
    logic                 table_hit;

    daf_cam_loader #(
        .N_ENTRIES (N_ENTRIES),
        .ADDR_W    (ADDR_W)
    ) u_loader (
        .clk        (clk),
        .rst        (rst),
        .load_start (load_start),
        .load_base  (load_base),
        .load_count (load_count),
        .load_busy  (load_busy),
        .load_done  (load_done),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .ent_we     (ent_we),
        .ent_idx    (ent_idx),
        .ent_data   (ent_data),
        .mask_we    (mask_we),
        .mask_data  (mask_data)
    );

    daf_cam_store #(
        .N_ENTRIES (N_ENTRIES)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .ent_we      (ent_we),
        .ent_idx     (ent_idx),
        .ent_data    (ent_data),
        .mask_we     (mask_we),
        .mask_data   (mask_data),
        .lookup_addr (dst_addr),
        .table_hit   (table_hit)
    );

    daf_classifier u_class (
        .clk          (clk),
        .rst          (rst),
        .match_start  (match_start),
        .rx_mode      (rx_mode),
        .dst_addr     (dst_addr),
        .table_hit    (table_hit),
        .match_valid  (match_valid),
        .match_accept (match_accept),
        .match_bcast  (match_bcast),
        .match_mcast  (match_mcast)
    );

endmodule

// File: rtl/daf_checker.sv
module daf_checker (
    input logic        clk,
    input logic        rst,
    input logic        match_start,
    input logic [2:0]  rx_mode,
    input logic [47:0] dst_addr,
    input logic        match_valid,
    input logic        match_accept,
    input logic        match_bcast,
    input logic        match_mcast,
    input logic        load_busy,
    input logic        load_done,
    input logic        rd_req,
    input logic        rd_valid
);

    AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (rst)
        match_start |-> ##2 match_valid); // R2

    AST_VALID_HAS_START: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> $past(match_start, 2)); // R2

    AST_PROMISC_TAKES: assert property (@(posedge clk) disable iff (rst)
        (match_start && rx_mode[0] && !dst_addr[0])
        |-> ##2 (match_accept && !match_bcast && !match_mcast)); // R3

    AST_ALLMC_TAKES: assert property (@(posedge clk) disable iff (rst)
        (match_start && !(rx_mode[0] && !dst_addr[0]) && rx_mode[1] && dst_addr[0])
        |-> ##2 (match_accept && match_mcast && !match_bcast)); // R4

    AST_FLAG_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (match_bcast || match_mcast) |-> (match_valid && match_accept)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !match_valid |-> !(match_accept || match_bcast || match_mcast)); // R7

    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        load_done |-> (!load_busy && $past(load_busy))); // R10

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req); // R11

    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (load_busy && !rd_valid)); // R11

endmodule

bind dest_addr_filter daf_checker u_daf_checker (
    .clk          (clk),
    .rst          (rst),
    .match_start  (match_start),
    .rx_mode      (rx_mode),
    .dst_addr     (dst_addr),
    .match_valid  (match_valid),
    .match_accept (match_accept),
    .match_bcast  (match_bcast),
    .match_mcast  (match_mcast),
    .load_busy    (load_busy),
    .load_done    (load_done),
    .rd_req       (rd_req),
    .rd_valid     (rd_valid)
);

// File: tb/dest_addr_filter_bench.sv
module dest_addr_filter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        match_start = 1'b0;
    logic [2:0]  rx_mode = '0;
    logic [47:0] dst_addr = '0;
    logic        match_valid, match_accept, match_bcast, match_mcast;
    logic        load_start = 1'b0;
    logic [15:0] load_base = '0;
    logic [4:0]  load_count = '0;
    logic        load_busy, load_done, rd_req;
    logic [15:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;

    always #10 clk = ~clk;

    dest_addr_filter u_dest_addr_filter (
        .clk(clk), .rst(rst), .match_start(match_start), .rx_mode(rx_mode),
        .dst_addr(dst_addr), .match_valid(match_valid), .match_accept(match_accept),
        .match_bcast(match_bcast), .match_mcast(match_mcast),
        .load_start(load_start), .load_base(load_base), .load_count(load_count),
        .load_busy(load_busy), .load_done(load_done), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int total = 0;
    int bad = 0;

    logic [15:0] mem [0:255];
    int nreq = 0;
    int viol = 0;

    logic [47:0] ref_ent [0:15];
    logic [15:0] ref_mask = '0;

    task automatic chk(input string tag, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Memory responder: one read at a time, latency 1..3 cycles
    initial begin : responder
        bit pend = 0;
        bit prev_req = 0;
        int wcnt = 0;
        logic [7:0] paddr = '0;
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (pend) begin
                if (wcnt == 0) begin
                    rd_valid = 1'b1;
                    rd_data  = mem[paddr];
                    pend     = 0;
                end else begin
                    wcnt--;
                end
            end
            if (rd_req === 1'b1) begin
                if (pend || prev_req) viol++;
                pend  = 1;
                paddr = rd_addr[7:0];
                wcnt  = nreq % 3;
                nreq++;
            end
            prev_req = (rd_req === 1'b1);
        end
    end

    function automatic logic [47:0] vaddr(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {8'hC0 + b, 8'h5E, 8'h33 ^ b, b, 8'hA5, 8'h20 + 8'(2 * i)};
    endfunction

    function automatic logic ref_hit(input logic [47:0] a);
        for (int k = 0; k < 16; k++)
            if (ref_mask[k] && ref_ent[k] == a) return 1'b1;
        return 1'b0;
    endfunction

    // Expected {accept, bcast, mcast}
    function automatic logic [2:0] ref_verdict(input logic [2:0] m, input logic [47:0] a);
        if (m[0] && !a[0]) return 3'b100;
        if (m[1] && a[0]) return 3'b101;
        if (m[2] && a == 48'hFFFF_FFFF_FFFF) return 3'b110;
        if (ref_hit(a)) return 3'b100;
        return 3'b000;
    endfunction

    function automatic string rule_tag(input logic [2:0] m, input logic [47:0] a);
        if (m[0] && !a[0]) return "R3";
        if (m[1] && a[0]) return "R4";
        if (m[2] && a == 48'hFFFF_FFFF_FFFF) return "R5";
        if (ref_hit(a)) return "R6";
        return "R7";
    endfunction

    task automatic put_desc(input int at, input int idx, input logic [47:0] a, input bit track);
        mem[at]     = 16'hC0F0 | 16'(idx);
        mem[at + 1] = a[15:0];
        mem[at + 2] = a[31:16];
        mem[at + 3] = a[47:32];
        if (track) ref_ent[idx] = a;
    endtask

    task automatic classify(input logic [2:0] m, input logic [47:0] a,
                            input logic [2:0] exp, input string tag);
        @(negedge clk);
        match_start = 1'b1;
        rx_mode     = m;
        dst_addr    = a;
        @(negedge clk);
        match_start = 1'b0;
        dst_addr    = ~a;
        rx_mode     = ~m;
        chk("R2", 64'(match_valid), 64'd0, "valid one edge after start");
        @(negedge clk);
        chk("R2", 64'(match_valid), 64'd1, "valid two edges after start");
        chk(tag, 64'({match_accept, match_bcast, match_mcast}), 64'(exp), "verdict");
        @(negedge clk);
        chk("R2", 64'(match_valid), 64'd0, "valid single cycle");
    endtask

    task automatic load_go(input logic [15:0] base, input logic [4:0] cnt);
        @(negedge clk);
        load_start = 1'b1;
        load_base  = base;
        load_count = cnt;
        @(negedge clk);
        load_start = 1'b0;
        load_base  = 16'hFFFF;
        load_count = 5'h1F;
    endtask

    task automatic wait_done();
        int g = 0;
        while (load_done !== 1'b1 && g < 3000) begin
            @(negedge clk);
            g++;
        end
        chk("R10", 64'(g < 3000), 64'd1, "done pulse seen");
        chk("R10", 64'(load_busy), 64'd0, "busy low with done");
        @(negedge clk);
        chk("R10", 64'(load_done), 64'd0, "done is one cycle");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int r0;
        logic [47:0] cls [0:3];
        logic [47:0] pa, qa;

        for (int k = 0; k < 256; k++) mem[k] = '0;
        for (int k = 0; k < 16; k++) ref_ent[k] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", 64'(match_valid), 64'd0, "valid after reset");
        chk("R1", 64'(load_busy), 64'd0, "busy after reset");
        chk("R1", 64'(load_done), 64'd0, "done after reset");
        chk("R1", 64'(rd_req), 64'd0, "req after reset");
        classify(3'b000, 48'h0, 3'b000, "R1");

        // Full load, reverse index order, with a start issued mid-walk
        for (int d = 0; d < 16; d++) put_desc(16'h40 + 4 * d, 15 - d, vaddr(15 - d), 1);
        mem[16'h80] = 16'hB3C5;
        for (int d = 0; d < 3; d++) put_desc(16'hE0 + 4 * d, 2, 48'h0000_0000_0BAD, 0);
        mem[16'hEC] = 16'hFFFF;
        r0 = nreq;
        load_go(16'h40, 5'd16);
        chk("R10", 64'(load_busy), 64'd1, "busy after start");
        repeat (5) @(negedge clk);
        load_go(16'hE0, 5'd3);
        wait_done();
        ref_mask = 16'hB3C5;
        chk("R9", 64'(nreq - r0), 64'd65, "request count for 16 descriptors");
        chk("R10", 64'(nreq - r0), 64'd65, "start while busy ignored");
        for (int i = 0; i < 16; i++)
            classify(3'b000, vaddr(i), ref_mask[i] ? 3'b100 : 3'b000, "R6");
        classify(3'b000, 48'h0000_0000_0BAD, 3'b000, "R10");

        // Same index loaded twice: the later descriptor wins
        pa = 48'h1111_2222_3344;
        qa = 48'h5566_7788_9900;
        put_desc(16'hA0, 5, pa, 1);
        put_desc(16'hA4, 5, qa, 1);
        mem[16'hA8] = 16'h0020;
        r0 = nreq;
        load_go(16'hA0, 5'd2);
        wait_done();
        ref_mask = 16'h0020;
        chk("R9", 64'(nreq - r0), 64'd9, "request count for 2 descriptors");
        classify(3'b000, qa, 3'b100, "R8");
        classify(3'b000, pa, 3'b000, "R8");
        classify(3'b000, vaddr(0), 3'b000, "R6");

        // Zero count: mask only
        mem[16'hC0] = 16'hFFFF;
        r0 = nreq;
        load_go(16'hC0, 5'd0);
        wait_done();
        ref_mask = 16'hFFFF;
        chk("R9", 64'(nreq - r0), 64'd1, "zero count reads only mask");
        for (int i = 0; i < 16; i++) classify(3'b000, ref_ent[i], 3'b100, "R9");
        chk("R11", 64'(viol), 64'd0, "request protocol violations");

        // Mode priority sweep
        cls[0] = vaddr(1);
        cls[1] = 48'h0000_0000_0012;
        cls[2] = 48'h0000_0000_0013;
        cls[3] = 48'hFFFF_FFFF_FFFF;
        for (int m = 0; m < 8; m++)
            for (int c = 0; c < 4; c++)
                classify(3'(m), cls[c], ref_verdict(3'(m), cls[c]), rule_tag(3'(m), cls[c]));

        // Back-to-back starts
        @(negedge clk);
        match_start = 1'b1; rx_mode = 3'b000; dst_addr = vaddr(1);
        @(negedge clk);
        chk("R2", 64'(match_valid), 64'd0, "b2b first edge");
        dst_addr = 48'h0000_0000_0012;
        @(negedge clk);
        match_start = 1'b0;
        chk("R2", 64'({match_valid, match_accept}), 64'b11, "b2b first result");
        @(negedge clk);
        chk("R2", 64'({match_valid, match_accept}), 64'b10, "b2b second result");
        @(negedge clk);
        chk("R2", 64'(match_valid), 64'd0, "b2b end");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule